// File: doc/BRIEF.md
# Software-Readable Action Queue Adapter

This block sits at the end of one event-action channel and turns its timed action records into something software can consume at its own pace. Each arriving record (64-bit event, 64-bit parameter, 32-bit tag, 32-bit TEF word, 64-bit timestamp, late and conflict flags) is stored in a small FIFO. Software reads the record at the head through a fixed window of 32-bit registers and retires it with a pop command. The FIFO has a fixed depth. A record that arrives while the FIFO is full is discarded and counted. The source is never stalled.

Two interrupt sources are delivered as single write transactions on a simple request/acknowledge master port. The arrival interrupt fires when a record is accepted. The overflow interrupt fires when a record is dropped. Software programs the target address of each source, and enables each one with its own mask bit. A metadata register reports which upstream unit and which channel feed this queue. The slave port `s_addr` carries bits 5:2 of the byte offset.

Top module: `action_queue_adapter`

## Requirements
- R1: The slave port raises `s_ack` for exactly one cycle, in the cycle after each single-cycle `s_stb`. Read data is valid on `s_rdata` while `s_ack` is high.
- R2: Records leave in arrival order. The head record is read at these byte offsets: event high 0x20, event low 0x24, parameter high 0x28, parameter low 0x2C, tag 0x30, TEF 0x34, time high 0x38, time low 0x3C. Reading the control register (0x00) returns the capacity 2^DEPTH_LOG2 in bits 31:16 and zero in bits 15:0.
- R3: Writing a value with bit 0 set to the control register removes the head record. The queued count at 0x10 reports the number of stored records. A pop on an empty queue is ignored, and writes to 0x10 are ignored.
- R4: While the queue is empty, the record field registers and the flags register read as zero.
- R5: The flags register (0x1C) reports the late flag of the head record in bit 0 and its conflict flag in bit 1. The metadata register (0x18) returns `unit_idx` in bits 31:24, `chan_idx` in bits 23:16 and zero in all other bits.
- R6: A record offered while the queue is full is discarded, and the queue contents and queued count are unchanged. The dropped count at 0x14 then increments, saturating at 2^DROP_W-1. A record offered in the same cycle as a pop on a full queue is also discarded.
- R7: A write to 0x14 loads the dropped count, so writing zero clears it.
- R8: The interrupt mask at 0x04 holds the arrival enable in bit 0 and the overflow enable in bit 1. Both bits read back, and the other bits read as zero. The arrival target address (0x08) and overflow target address (0x0C) are 32-bit read/write registers.
- R9: With the arrival enable set, an accepted record causes one master write to the arrival address. Its data is the queued count when the request is raised. `m_req`, `m_addr` and `m_data` hold steady until `m_ack`, and `m_req` drops in the cycle after the acknowledge.
- R10: With the overflow enable set, a dropped record causes one master write to the overflow address, with the dropped count as data. When both sources are pending, the overflow write is issued first.
- R11: With an enable bit clear, its source produces no master write, and clearing the bit discards that source's pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Record offered this cycle |
| in_event | input | 64 | Event word of the offered record |
| in_param | input | 64 | Parameter word |
| in_tag | input | 32 | Tag |
| in_tef | input | 32 | TEF word |
| in_time | input | 64 | Execution timestamp |
| in_late | input | 1 | Record was late |
| in_conflict | input | 1 | Record was a conflict |
| unit_idx | input | 8 | Index of the upstream unit (held static) |
| chan_idx | input | 8 | Index of the feeding channel (held static) |
| s_stb | input | 1 | Slave access strobe, one cycle per access |
| s_we | input | 1 | Slave write enable |
| s_addr | input | 4 | Word index (byte offset bits 5:2) |
| s_wdata | input | 32 | Slave write data |
| s_ack | output | 1 | Slave acknowledge, one cycle after the strobe |
| s_rdata | output | 32 | Slave read data |
| m_req | output | 1 | Interrupt write request |
| m_addr | output | 32 | Interrupt write address |
| m_data | output | 32 | Interrupt write data |
| m_ack | input | 1 | Interrupt write acknowledge |

## Verification
The bench fills the queue to capacity and keeps offering records. A design that stored an overflow record, or let the dropped count wrap, would show a wrong head record or a small count after the long burst. It pops an empty queue and reads the record window there. A design that moved its pointers on that pop would report a nonzero count or stale fields. It also leaves an interrupt write unacknowledged while an accepted record and a dropped record arrive behind it. This exposes a generator that loses a pending source, drops the request before the acknowledge, or sends the arrival write ahead of the overflow write.

// File: rtl/aq_pkg.sv
// Package: shared record type and register word indices for the action
// queue adapter. Word indices are byte offset bits 5:2 of the window.
package aq_pkg;

    typedef struct packed {
        logic [63:0] evt;
        logic [63:0] prm;
        logic [31:0] tag;
        logic [31:0] tef;
        logic [63:0] tstamp;
        logic        late;
        logic        conflict;
    } aq_rec_t;

    localparam logic [3:0] W_CTRL  = 4'h0;
    localparam logic [3:0] W_MASK  = 4'h1;
    localparam logic [3:0] W_ARRA  = 4'h2;
    localparam logic [3:0] W_OVFA  = 4'h3;
    localparam logic [3:0] W_QCNT  = 4'h4;
    localparam logic [3:0] W_DROP  = 4'h5;
    localparam logic [3:0] W_META  = 4'h6;
    localparam logic [3:0] W_FLAG  = 4'h7;
    localparam logic [3:0] W_EVTH  = 4'h8;
    localparam logic [3:0] W_EVTL  = 4'h9;
    localparam logic [3:0] W_PRMH  = 4'hA;
    localparam logic [3:0] W_PRML  = 4'hB;
    localparam logic [3:0] W_TAG   = 4'hC;
    localparam logic [3:0] W_TEF   = 4'hD;
    localparam logic [3:0] W_TIMH  = 4'hE;
    localparam logic [3:0] W_TIML  = 4'hF;

endpackage

// File: rtl/aq_fifo.sv
// Module: aq_fifo
// Circular record store with an occupancy counter. A push on a full store
// and a pop on an empty store are both ignored. The head record is shown
// combinationally on rd_rec; its content is meaningless while empty.
// Assumes: DEPTH_LOG2 >= 1.
module aq_fifo
    import aq_pkg::*;
#(
    parameter int DEPTH_LOG2 = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  aq_rec_t             wr_rec,
    input  logic                pop,
    output aq_rec_t             rd_rec,
    output logic [DEPTH_LOG2:0] count,
    output logic                full,
    output logic                empty
);
    localparam int DEPTH = 1 << DEPTH_LOG2;

    aq_rec_t                 mem [DEPTH];
    logic [DEPTH_LOG2-1:0]   wptr;
    logic [DEPTH_LOG2-1:0]   rptr;
    logic                    do_push;
    logic                    do_pop;

    assign full    = (count == (DEPTH_LOG2+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_rec  = mem[rptr];

    // Storage write; the array carries no reset, validity comes from count.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wr_rec;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/aq_regs.sv
// Module: aq_regs
// Register window decode. Holds the interrupt mask, both interrupt target
// addresses and the saturating dropped counter; generates the pop command
// and returns read data one cycle after the strobe.
// Assumes: s_stb is a single-cycle pulse per access, DROP_W <= 32.
module aq_regs
    import aq_pkg::*;
#(
    parameter int DEPTH_LOG2 = 3,
    parameter int DROP_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_stb,
    input  logic                s_we,
    input  logic [3:0]          s_addr,
    input  logic [31:0]         s_wdata,
    output logic                s_ack,
    output logic [31:0]         s_rdata,
    input  aq_rec_t             head,
    input  logic [DEPTH_LOG2:0] q_count,
    input  logic [7:0]          unit_idx,
    input  logic [7:0]          chan_idx,
    input  logic                drop_evt,
    output logic                pop_cmd,
    output logic                arr_en,
    output logic                ovf_en,
    output logic [31:0]         arr_addr,
    output logic [31:0]         ovf_addr,
    output logic [DROP_W-1:0]   drop_cnt
);
    localparam int          DEPTH    = 1 << DEPTH_LOG2;
    localparam logic [15:0] CAPACITY = 16'(DEPTH);
    localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

    logic        wr;
    logic        has_rec;
    logic [31:0] rd_next;

    assign wr      = s_stb && s_we;
    assign has_rec = (q_count != '0);
    assign pop_cmd = wr && (s_addr == W_CTRL) && s_wdata[0];

    // Read data selection for the addressed word.
    always_comb begin
        rd_next = '0;
        unique case (s_addr)
            W_CTRL: rd_next = {CAPACITY, 16'h0000};
            W_MASK: rd_next = {30'd0, ovf_en, arr_en};
            W_ARRA: rd_next = arr_addr;
            W_OVFA: rd_next = ovf_addr;
            W_QCNT: rd_next = 32'(q_count);
            W_DROP: rd_next = 32'(drop_cnt);
            W_META: rd_next = {unit_idx, chan_idx, 16'h0000};
            W_FLAG: rd_next = has_rec ? {30'd0, head.conflict, head.late} : '0;
            W_EVTH: rd_next = has_rec ? head.evt[63:32]    : '0;
            W_EVTL: rd_next = has_rec ? head.evt[31:0]     : '0;
            W_PRMH: rd_next = has_rec ? head.prm[63:32]    : '0;
            W_PRML: rd_next = has_rec ? head.prm[31:0]     : '0;
            W_TAG:  rd_next = has_rec ? head.tag           : '0;
            W_TEF:  rd_next = has_rec ? head.tef           : '0;
            W_TIMH: rd_next = has_rec ? head.tstamp[63:32] : '0;
            W_TIML: rd_next = has_rec ? head.tstamp[31:0]  : '0;
            default: rd_next = '0;
        endcase
    end

    // Acknowledge and read data register, one cycle behind the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_ack   <= 1'b0;
            s_rdata <= '0;
        end else begin
            s_ack   <= s_stb;
            if (s_stb && !s_we) s_rdata <= rd_next;
        end
    end

    // Software-writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_en   <= 1'b0;
            ovf_en   <= 1'b0;
            arr_addr <= '0;
            ovf_addr <= '0;
        end else if (wr) begin
            if (s_addr == W_MASK) begin
                arr_en <= s_wdata[0];
                ovf_en <= s_wdata[1];
            end
            if (s_addr == W_ARRA) arr_addr <= s_wdata;
            if (s_addr == W_OVFA) ovf_addr <= s_wdata;
        end
    end

    // Dropped counter: a software write wins, otherwise saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_cnt <= '0;
        end else if (wr && s_addr == W_DROP) begin
            drop_cnt <= s_wdata[DROP_W-1:0];
        end else if (drop_evt && drop_cnt != DROP_MAX) begin
            drop_cnt <= drop_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/aq_irq.sv
// Module: aq_irq
// Interrupt message generator. Each source keeps one sticky pending bit
// (repeated events coalesce). When the master port is idle, a pending
// source is launched as one write; overflow has priority over arrival.
// The request holds address and data until acknowledged.
// Assumes: m_ack is only meaningful while m_req is high.
module aq_irq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arr_evt,
    input  logic        ovf_evt,
    input  logic        arr_en,
    input  logic        ovf_en,
    input  logic [31:0] arr_addr,
    input  logic [31:0] ovf_addr,
    input  logic [31:0] arr_data,
    input  logic [31:0] ovf_data,
    input  logic        m_ack,
    output logic        m_req,
    output logic [31:0] m_addr,
    output logic [31:0] m_data
);
    logic arr_pend;
    logic ovf_pend;
    logic go_ovf;
    logic go_arr;

    assign go_ovf = !m_req && ovf_pend;
    assign go_arr = !m_req && !ovf_pend && arr_pend;

    // Pending bits: set by an enabled event, cleared on launch or disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_pend <= 1'b0;
            ovf_pend <= 1'b0;
        end else begin
            arr_pend <= arr_en && ((arr_pend && !go_arr) || arr_evt);
            ovf_pend <= ovf_en && ((ovf_pend && !go_ovf) || ovf_evt);
        end
    end

    // Master request: launch a pending source, release on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_req  <= 1'b0;
            m_addr <= '0;
            m_data <= '0;
        end else if (m_req) begin
            if (m_ack) m_req <= 1'b0;
        end else if (go_ovf) begin
            m_req  <= 1'b1;
            m_addr <= ovf_addr;
            m_data <= ovf_data;
        end else if (go_arr) begin
            m_req  <= 1'b1;
            m_addr <= arr_addr;
            m_data <= arr_data;
        end
    end

endmodule

// File: rtl/action_queue_adapter.sv
// Module: action_queue_adapter (top)
// Buffers timed action records from one channel in a FIFO, exposes the
// head record through a 32-bit register window, drops and counts records
// that find the FIFO full, and reports arrivals and overflows as master
// writes to programmable addresses.
// Assumes: unit_idx/chan_idx static; one clock domain; DROP_W <= 32.
module action_queue_adapter
    import aq_pkg::*;
#(
    parameter int DEPTH_LOG2 = 3,
    parameter int DROP_W     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [63:0] in_event,
    input  logic [63:0] in_param,
    input  logic [31:0] in_tag,
    input  logic [31:0] in_tef,
    input  logic [63:0] in_time,
    input  logic        in_late,
    input  logic        in_conflict,
    input  logic [7:0]  unit_idx,
    input  logic [7:0]  chan_idx,
    input  logic        s_stb,
    input  logic        s_we,
    input  logic [3:0]  s_addr,
    input  logic [31:0] s_wdata,
    output logic        s_ack,
    output logic [31:0] s_rdata,
    output logic        m_req,
    output logic [31:0] m_addr,
    output logic [31:0] m_data,
    input  logic        m_ack
);
    aq_rec_t               in_rec;
    aq_rec_t               head;
    logic [DEPTH_LOG2:0]   q_count;
    logic                  q_full;
    logic                  q_empty;
    logic                  pop_cmd;
    logic                  arr_evt;
    logic                  drop_evt;
    logic                  arr_en;
    logic                  ovf_en;
    logic [31:0]           arr_addr;
    logic [31:0]           ovf_addr;
    logic [DROP_W-1:0]     drop_cnt;

    assign in_rec   = '{evt: in_event, prm: in_param, tag: in_tag, tef: in_tef,
                        tstamp: in_time, late: in_late, conflict: in_conflict};
    assign arr_evt  = in_valid && !q_full;
    assign drop_evt = in_valid && q_full;

    aq_fifo #(.DEPTH_LOG2(DEPTH_LOG2)) fifo_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (in_valid),
        .wr_rec (in_rec),
        .pop    (pop_cmd),
        .rd_rec (head),
        .count  (q_count),
        .full   (q_full),
        .empty  (q_empty)
    );

    aq_regs #(.DEPTH_LOG2(DEPTH_LOG2), .DROP_W(DROP_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_stb    (s_stb),
        .s_we     (s_we),
        .s_addr   (s_addr),
        .s_wdata  (s_wdata),
        .s_ack    (s_ack),
        .s_rdata  (s_rdata),
        .head     (head),
        .q_count  (q_count),
        .unit_idx (unit_idx),
        .chan_idx (chan_idx),
        .drop_evt (drop_evt),
        .pop_cmd  (pop_cmd),
        .arr_en   (arr_en),
        .ovf_en   (ovf_en),
        .arr_addr (arr_addr),
        .ovf_addr (ovf_addr),
        .drop_cnt (drop_cnt)
    );

    aq_irq irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .arr_evt  (arr_evt),
        .ovf_evt  (drop_evt),
        .arr_en   (arr_en),
        .ovf_en   (ovf_en),
        .arr_addr (arr_addr),
        .ovf_addr (ovf_addr),
        .arr_data (32'(q_count)),
        .ovf_data (32'(drop_cnt)),
        .m_ack    (m_ack),
        .m_req    (m_req),
        .m_addr   (m_addr),
        .m_data   (m_data)
    );

endmodule

// File: rtl/aq_adapter_chk.sv
// Module: aq_adapter_chk
// Protocol and state checks for action_queue_adapter, bound to every
// instance of the top module.
module aq_adapter_chk #(
    parameter int DEPTH_LOG2 = 3,
    parameter int DROP_W     = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                s_stb,
    input logic                s_we,
    input logic [3:0]          s_addr,
    input logic                s_ack,
    input logic                in_valid,
    input logic                m_req,
    input logic                m_ack,
    input logic [31:0]         m_addr,
    input logic [31:0]         m_data,
    input logic [DEPTH_LOG2:0] q_count,
    input logic [DROP_W-1:0]   drop_cnt
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

    // R1: every strobe is acknowledged in the next cycle
    a_r1_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        s_stb |=> s_ack);

    // R1: no acknowledge without a preceding strobe
    a_r1_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !s_stb |=> !s_ack);

    // R3: occupancy never exceeds capacity
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= (DEPTH_LOG2+1)'(DEPTH));

    // R3: an empty queue with no arrival stays empty, whatever is popped
    a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == '0 && !in_valid) |=> q_count == '0);

    // R6: the dropped counter does not wrap once saturated
    a_r6_drop_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt == DROP_MAX && !(s_stb && s_we && s_addr == 4'h5))
        |=> drop_cnt == DROP_MAX);

    // R9: an unacknowledged request keeps its address and data
    a_r9_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_data)));

    // R9: an acknowledged request is released in the next cycle
    a_r9_req_release: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ack) |=> !m_req);

endmodule

bind action_queue_adapter aq_adapter_chk #(
    .DEPTH_LOG2 (DEPTH_LOG2),
    .DROP_W     (DROP_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_stb    (s_stb),
    .s_we     (s_we),
    .s_addr   (s_addr),
    .s_ack    (s_ack),
    .in_valid (in_valid),
    .m_req    (m_req),
    .m_ack    (m_ack),
    .m_addr   (m_addr),
    .m_data   (m_data),
    .q_count  (q_count),
    .drop_cnt (drop_cnt)
);

// File: tb/action_queue_adapter_tb_top.sv
// Bench for action_queue_adapter: a table of records pushed and popped in
// one loop, then directed tests for interrupts, overflow and saturation.
module action_queue_adapter_tb_top;

    localparam int NTAB = 6;
    localparam logic [63:0] EVT_TAB [NTAB] = '{
        64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_0000_0001,
        64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000,
        64'hDEAD_BEEF_CAFE_F00D, 64'h5555_AAAA_3333_CCCC};
    localparam logic [31:0] ARR_TGT = 32'h1000_0040;
    localparam logic [31:0] OVF_TGT = 32'h2000_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_event = '0;
    logic [63:0] in_param = '0;
    logic [31:0] in_tag = '0;
    logic [31:0] in_tef = '0;
    logic [63:0] in_time = '0;
    logic        in_late = 1'b0;
    logic        in_conflict = 1'b0;
    logic [7:0]  unit_idx = 8'hA5;
    logic [7:0]  chan_idx = 8'h3C;
    logic        s_stb = 1'b0;
    logic        s_we = 1'b0;
    logic [3:0]  s_addr = '0;
    logic [31:0] s_wdata = '0;
    logic        s_ack;
    logic [31:0] s_rdata;
    logic        m_req;
    logic [31:0] m_addr;
    logic [31:0] m_data;
    logic        m_ack = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    action_queue_adapter dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_event(in_event),
        .in_param(in_param), .in_tag(in_tag), .in_tef(in_tef),
        .in_time(in_time), .in_late(in_late), .in_conflict(in_conflict),
        .unit_idx(unit_idx), .chan_idx(chan_idx), .s_stb(s_stb),
        .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_ack(s_ack),
        .s_rdata(s_rdata), .m_req(m_req), .m_addr(m_addr),
        .m_data(m_data), .m_ack(m_ack));

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        s_stb = 1'b1; s_we = 1'b0; s_addr = a;
        @(posedge clk); @(negedge clk);
        s_stb = 1'b0;
        chk("R1 ack", 64'(s_ack), 64'd1);
        d = s_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        s_stb = 1'b1; s_we = 1'b1; s_addr = a; s_wdata = d;
        @(posedge clk); @(negedge clk);
        s_stb = 1'b0; s_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a,
                          input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, 64'(d), 64'(exp));
    endtask

    // Drives one record whose fields derive from evt and k.
    task automatic push(input logic [63:0] evt, input int k);
        in_valid = 1'b1; in_event = evt; in_param = ~evt;
        in_tag = evt[63:32] ^ evt[31:0]; in_tef = {evt[15:0], evt[31:16]};
        in_time = evt + 64'd1000; in_late = k[0]; in_conflict = k[1];
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic head_chk(input logic [63:0] evt, input int k);
        logic [63:0] p = ~evt;
        logic [63:0] t = evt + 64'd1000;
        rd_chk("R2 evt hi", 4'h8, evt[63:32]);
        rd_chk("R2 evt lo", 4'h9, evt[31:0]);
        rd_chk("R2 prm hi", 4'hA, p[63:32]);
        rd_chk("R2 prm lo", 4'hB, p[31:0]);
        rd_chk("R2 tag",    4'hC, evt[63:32] ^ evt[31:0]);
        rd_chk("R2 tef",    4'hD, {evt[15:0], evt[31:16]});
        rd_chk("R2 time hi", 4'hE, t[63:32]);
        rd_chk("R2 time lo", 4'hF, t[31:0]);
        rd_chk("R5 flags",  4'h7, {30'd0, k[1], k[0]});
    endtask

    task automatic wait_req(input string req, input logic [31:0] ea,
                            input logic [31:0] ed);
        int n = 0;
        while (!m_req && n < 20) begin
            @(negedge clk); n++;
        end
        chk({req, " req"}, 64'(m_req), 64'd1);
        chk({req, " addr"}, 64'(m_addr), 64'(ea));
        chk({req, " data"}, 64'(m_data), 64'(ed));
    endtask

    task automatic ack_req();
        m_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        m_ack = 1'b0;
        chk("R9 release", 64'(m_req), 64'd0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R1 reset ack", 64'(s_ack), 64'd0);
        chk("R11 reset req", 64'(m_req), 64'd0);
        rd_chk("R3 reset count", 4'h4, 32'd0);
        rd_chk("R2 capacity", 4'h0, 32'h0008_0000);
        rd_chk("R8 reset mask", 4'h1, 32'd0);
        rd_chk("R6 reset drops", 4'h5, 32'd0);
        rd_chk("R4 empty flags", 4'h7, 32'd0);
        rd_chk("R4 empty evt", 4'h8, 32'd0);
        rd_chk("R5 meta", 4'h6, 32'hA53C_0000);

        // Pop on empty is ignored; count register is not writable
        wr(4'h0, 32'd1);
        rd_chk("R3 empty pop", 4'h4, 32'd0);
        wr(4'h4, 32'd5);
        rd_chk("R3 count ro", 4'h4, 32'd0);

        // Table walk: push all, then read and pop in order
        for (int i = 0; i < NTAB; i++) begin
            push(EVT_TAB[i], i);
            chk("R11 no irq", 64'(m_req), 64'd0);
            rd_chk("R3 count up", 4'h4, 32'(i + 1));
        end
        for (int i = 0; i < NTAB; i++) begin
            head_chk(EVT_TAB[i], i);
            wr(4'h0, 32'd1);
            rd_chk("R3 count down", 4'h4, 32'(NTAB - 1 - i));
        end
        rd_chk("R4 drained tef", 4'hD, 32'd0);

        // Mask register
        wr(4'h1, 32'hFFFF_FFFF);
        rd_chk("R8 mask", 4'h1, 32'd3);
        wr(4'h1, 32'd0);
        wr(4'h2, ARR_TGT);
        wr(4'h3, OVF_TGT);
        rd_chk("R8 arr addr", 4'h2, ARR_TGT);
        rd_chk("R8 ovf addr", 4'h3, OVF_TGT);

        // Arrival interrupt, held until acknowledged
        wr(4'h1, 32'd1);
        push(64'hF00D_0000_0000_0001, 0);
        wait_req("R9 arrival", ARR_TGT, 32'd1);
        repeat (3) @(negedge clk);
        wait_req("R9 held", ARR_TGT, 32'd1);
        ack_req();
        wr(4'h1, 32'd0);

        // Fill to capacity, then overflow
        for (int i = 2; i <= 8; i++) push(64'hF00D_0000_0000_0000 + 64'(i), 0);
        rd_chk("R3 full", 4'h4, 32'd8);
        chk("R11 masked", 64'(m_req), 64'd0);
        wr(4'h1, 32'd2);
        push(64'hF00D_0000_0000_0009, 0);
        wait_req("R10 overflow", OVF_TGT, 32'd1);
        ack_req();
        rd_chk("R6 drop count", 4'h5, 32'd1);
        rd_chk("R6 count kept", 4'h4, 32'd8);
        rd_chk("R6 head kept", 4'h9, 32'd1);

        // Priority: arrival outstanding, then one drop and one accept
        wr(4'h1, 32'd3);
        wr(4'h0, 32'd1);
        push(64'hF00D_0000_0000_000A, 0);
        wait_req("R9 arrival2", ARR_TGT, 32'd8);
        push(64'hF00D_0000_0000_000B, 0);
        wr(4'h0, 32'd1);
        push(64'hF00D_0000_0000_000C, 0);
        ack_req();
        wait_req("R10 priority", OVF_TGT, 32'd2);
        ack_req();
        wait_req("R9 after ovf", ARR_TGT, 32'd8);
        ack_req();
        wr(4'h1, 32'd0);

        // Disabling a source drops its pending request
        wr(4'h1, 32'd1);
        wr(4'h0, 32'd1);
        push(64'hF00D_0000_0000_000D, 0);
        wait_req("R9 arrival3", ARR_TGT, 32'd8);
        wr(4'h0, 32'd1);
        push(64'hF00D_0000_0000_000E, 0);
        wr(4'h1, 32'd0);
        ack_req();
        repeat (4) @(negedge clk);
        chk("R11 pend cleared", 64'(m_req), 64'd0);

        // Saturation of the dropped counter
        in_valid = 1'b1;
        repeat (300) @(negedge clk);
        in_valid = 1'b0;
        rd_chk("R6 saturate", 4'h5, 32'd255);
        rd_chk("R6 full count", 4'h4, 32'd8);
        chk("R11 no ovf irq", 64'(m_req), 64'd0);
        wr(4'h5, 32'd0);
        rd_chk("R7 clear", 4'h5, 32'd0);
        wr(4'h5, 32'd7);
        rd_chk("R7 load", 4'h5, 32'd7);

        // Drain completely, then one extra pop
        for (int i = 0; i < 9; i++) wr(4'h0, 32'd1);
        rd_chk("R3 drained", 4'h4, 32'd0);
        rd_chk("R4 drained flags", 4'h7, 32'd0);
        rd_chk("R4 drained time", 4'hF, 32'd0);

        done = 1'b1;
        finish_run();
    end

endmodule